// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block gathers interrupt requests from up to eight device lines and presents them to a processor as one request signal. Each line is edge-sensitive. A rising edge latches a pending request, and the request stays latched while the line remains high. Several lines may fire in the same cycle and every one of them is kept. The controller forwards the highest-priority unmasked pending line by raising its request output. When the processor acknowledges, the controller returns an 8-bit type number for that source. The number is built from a programmable base and the line index.

After an acknowledge the source counts as in service. No new request goes to the processor until software issues an end-of-interrupt command, even when other lines are pending. A small register write port sets the vector base and the per-line mask, and it also carries the end-of-interrupt command. The acknowledge exchange is a two-signal handshake. The processor raises `inta_i` only while `intr_o` is high. The controller answers with a one-cycle `vec_valid_o` pulse carrying `vec_o`. There is no back-pressure on the vector, because the processor asked for it in the previous cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A rising edge on `irq_i[n]` sets pending bit n from the next clock edge. Edges on several lines in the same cycle are all kept. A line that stays high after it has been acknowledged does not become pending again until it falls and rises once more.
- R2: A pending bit whose line goes low before it is acknowledged is cleared at the next clock edge. If it was the only forwardable request, `intr_o` is low in the following cycle.
- R3: Mask bit n set to 1 keeps line n from raising `intr_o`, but its pending bit is retained. Clearing the mask bit forwards the request from the cycle after the write.
- R4: `intr_o` is high exactly when at least one unmasked pending bit exists and no source is in service.
- R5: Priority is fixed. Among the unmasked pending lines, the lowest index wins.
- R6: An acknowledge (`inta_i` high while `intr_o` is high) produces, one cycle later, a single-cycle `vec_valid_o` pulse with `vec_o` = {base[7:3], winning index[2:0]}. `inta_i` while `intr_o` is low is ignored.
- R7: An acknowledge clears the winner's pending bit and marks it in service. While any source is in service, `intr_o` stays low.
- R8: A register write to address 2 (end of interrupt) clears the in-service state. From the next cycle `intr_o` again reflects the remaining pending lines.
- R9: Register writes go to address 0, which keeps data bits 7:3 as the vector base, and to address 1, which is the mask with bit n belonging to line n. Reset clears the base, the mask, all pending and in-service state, `intr_o` and `vec_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Device request lines, bit n is line n |
| inta_i | input | 1 | Processor acknowledge |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 base, 1 mask, 2 end of interrupt |
| cfg_wdata_i | input | 8 | Register write data |
| intr_o | output | 1 | Request to the processor |
| vec_valid_o | output | 1 | Vector valid pulse, one cycle after acknowledge |
| vec_o | output | 8 | Type number of the acknowledged source |

## Verification
The request lines are registered once. The bench therefore expects `intr_o` to respond one clock edge after an edge, drop, mask write or end-of-interrupt write, because `intr_o` is combinational on registered state. `vec_valid_o` and `vec_o` appear one edge after an acknowledge, and `intr_o` falls at that same edge. All inputs are driven on the falling clock edge and every result is sampled at the next falling edge, which lies half a period after the edge that updates it. Random line sets, masks and bases are checked against a bench priority function, and the second-priority source is checked after each end of interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef logic [1:0] cfg_addr_t;
  localparam cfg_addr_t CFG_BASE = 2'd0;
  localparam cfg_addr_t CFG_MASK = 2'd1;
  localparam cfg_addr_t CFG_EOI  = 2'd2;
endpackage

// File: rtl/irqc_req_latch.sv
// Edge capture and pending latch, one slot per source line.
module irqc_req_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] line_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] line_q;
  logic [N_SRC-1:0] pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        line_q[g] <= line_i[g];
        // set on a rising edge, drop when the line falls or on acknowledge
        pend_q[g] <= (pend_q[g] | (line_i[g] & ~line_q[g])) & line_i[g] & ~clr_i[g];
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_prio_pick.sv
// Fixed priority: the lowest index wins.
module irqc_prio_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = N_SRC'(1) << i;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irqc_cfg_regs.sv
// Vector base and mask registers plus the end-of-interrupt strobe.
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = $clog2(N_SRC),
  parameter int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  cfg_addr_t         addr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              eoi_o
);
  logic [BASE_W-1:0] base_q;
  logic [N_SRC-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_BASE) base_q <= wdata_i[VEC_W-1:IDX_W];
      if (addr_i == CFG_MASK) mask_q <= wdata_i[N_SRC-1:0];
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign eoi_o  = we_i && (addr_i == CFG_EOI);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             inta_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [VEC_W-1:0] cfg_wdata_i,
  output logic             intr_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  mask;
  logic [N_SRC-1:0]  active;
  logic [N_SRC-1:0]  win_oh;
  logic [N_SRC-1:0]  clr;
  logic [N_SRC-1:0]  isr_q;
  logic [IDX_W-1:0]  win_idx;
  logic [BASE_W-1:0] base;
  logic              any_active;
  logic              eoi;
  logic              ack;
  logic              vec_valid_q;
  logic [VEC_W-1:0]  vec_q;

  irqc_cfg_regs #(.N_SRC(N_SRC), .VEC_W(VEC_W)) i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_t'(cfg_addr_i)),
    .wdata_i(cfg_wdata_i),
    .base_o (base),
    .mask_o (mask),
    .eoi_o  (eoi)
  );

  irqc_req_latch #(.N_SRC(N_SRC)) i_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(irq_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  assign active = pend & ~mask;

  irqc_prio_pick #(.N_SRC(N_SRC)) i_pick (
    .req_i   (active),
    .any_o   (any_active),
    .idx_o   (win_idx),
    .onehot_o(win_oh)
  );

  assign intr_o = any_active && (isr_q == '0);
  assign ack    = inta_i && intr_o;
  assign clr    = ack ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q       <= '0;
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      isr_q       <= (eoi ? '0 : isr_q) | clr;
      vec_valid_q <= ack;
      if (ack) vec_q <= {base, win_idx};
    end
  end

  assign vec_valid_o = vec_valid_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] isr,
  input logic             intr,
  input logic             inta,
  input logic             eoi,
  input logic             vec_valid
);
  AST_PEND_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(irq)) == '0); // R2
  AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (isr != '0) |-> !intr); // R7
  AST_ONE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr)); // R7
  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && intr) |=> ($countones(isr) == 1)); // R7
  AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && intr)); // R6
  AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (isr == '0)); // R8
endmodule

bind irq_vector_ctrl irqc_checker #(.N_SRC(N_SRC)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_i),
  .pend     (pend),
  .isr      (isr_q),
  .intr     (intr_o),
  .inta     (inta_i),
  .eoi      (eoi),
  .vec_valid(vec_valid_o)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       inta = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       intr;
  logic       vvalid;
  logic [7:0] vec;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .inta_i(inta),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .intr_o(intr), .vec_valid_o(vvalid), .vec_o(vec)
  );

  function automatic int winner(logic [7:0] lines, logic [7:0] msk);
    for (int i = 0; i < 8; i++) if (lines[i] && !msk[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ack();
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(intr == 0 && vvalid == 0 && vec == 0, "R9 reset", {intr, vvalid, vec}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 + R5 + R6: two lines together, base 0x48
    cfg(2'd0, 8'h4D);
    irq = 8'b0010_0100;
    @(negedge clk);
    check(intr == 1, "R4 intr after edge", intr, 1);
    ack();
    check(vvalid == 1 && vec == 8'h4A, "R6 vector line2", vec, 8'h4A);
    check(intr == 0, "R7 held off in service", intr, 0);
    @(negedge clk);
    check(vvalid == 0, "R6 single pulse", vvalid, 0);
    cfg(2'd2, 8'h00);
    check(intr == 1, "R8 eoi releases line5", intr, 1);
    ack();
    check(vec == 8'h4D, "R1 second latched line kept", vec, 8'h4D);
    cfg(2'd2, 8'h00);
    check(intr == 0, "R1 held-high line not re-pended", intr, 0);
    irq = 8'h00;
    @(negedge clk);

    // R6: acknowledge with intr low is ignored
    ack();
    check(vvalid == 0, "R6 spurious ack ignored", vvalid, 0);

    // R3: masked line keeps its pending bit
    cfg(2'd1, 8'h08);
    irq = 8'h08;
    @(negedge clk);
    check(intr == 0, "R3 masked line quiet", intr, 0);
    cfg(2'd1, 8'h00);
    check(intr == 1, "R3 unmask forwards", intr, 1);

    // R2: line drops before acknowledge
    irq = 8'h00;
    @(negedge clk);
    check(intr == 0, "R2 dropped request", intr, 0);

    // random rounds
    for (int r = 0; r < 60; r++) begin
      logic [7:0] lines, msk;
      int w, w2;
      lines = 8'($urandom);
      msk   = 8'($urandom) & 8'($urandom);
      base  = 8'($urandom);
      cfg(2'd0, base);
      cfg(2'd1, msk);
      irq = lines;
      @(negedge clk);
      w = winner(lines, msk);
      check(intr == (w >= 0), "R4 random intr", intr, w >= 0);
      if (w >= 0) begin
        ack();
        check(vvalid && vec == {base[7:3], 3'(w)}, "R5 random vector", vec, {base[7:3], 3'(w)});
        check(intr == 0, "R7 random hold off", intr, 0);
        cfg(2'd2, 8'h00);
        w2 = winner(lines & ~(8'd1 << w), msk);
        check(intr == (w2 >= 0), "R8 random next", intr, w2 >= 0);
        if (w2 >= 0) begin
          ack();
          check(vec == {base[7:3], 3'(w2)}, "R5 random second", vec, {base[7:3], 3'(w2)});
          cfg(2'd2, 8'h00);
        end
      end
      irq = 8'h00;
      @(negedge clk);
      cfg(2'd1, 8'h00);
      check(intr == 0, "R2 random drop clears", intr, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule